// File: doc/BRIEF.md
# Flash Program Suspend Controller

This block is the command-level part of a multi-partition flash write state machine that handles pausing and resuming a program operation. A host writes command bytes tagged with a partition number. A separate start strobe launches a program of a given length on one partition. The program runs as a chain of checkpoints, one every `CHK_INTERVAL` cycles, and the progress count advances only when a checkpoint is reached.

A suspend request does not stop the program at once. It is held until the next checkpoint, and the program halts there. While the program is halted, the controller accepts only the read-mode commands and the resume command. Every other command is dropped.

Each partition has its own two-bit read mode. A partition that is in a data mode (array, identifier or query) returns data with no further command. A partition in status mode returns status. An erase-suspended flag from elsewhere is carried into the status byte, so a program that runs inside a suspended erase can itself be suspended.

Top module: `flashSuspendCtl`

## Requirements
- R1: After reset, status is 0x80 (bit 7 ready set, all other bits clear), every partition mode is 2'b00 (array) and the progress count is 0.
- R2: A start strobe sampled while idle clears status bit 7 one cycle later and puts the target partition in status mode 2'b01. The progress count restarts at 0. A start strobe while a program is running or suspended is ignored.
- R3: While running, the progress count rises by one every `CHK_INTERVAL` cycles. After the checkpoint that makes the count equal the programmed length (a length of 0 acts as 1), status bit 7 sets and the count holds at that length.
- R4: The suspend command (0xB0) has no immediate effect while running. At the next checkpoint that does not finish the program, status bits 7 and 2 set together and the progress count stops moving.
- R5: The suspend command leaves the read mode of the partition named with it unchanged.
- R6: The suspended partition stays in status mode (2'b01) until a read-mode command is written to it.
- R7: While suspended, only 0xFF, 0x70, 0x90, 0x98 and the resume command 0xD0 act. Any other byte, a repeated 0xB0 and the start strobe leave the status, the modes and the count unchanged.
- R8: Resume (0xD0) while suspended clears status bits 7 and 2 one cycle later. Progress continues from the held count, and bit 7 sets again on completion. 0xD0 at any other time is ignored.
- R9: A suspend command while idle is ignored and leaves the status at its current value.
- R10: Status bit 6 follows the erase-suspended input with one cycle of delay. It can be set together with bit 2 when a program started during an erase suspend is itself suspended.
- R11: While running, read-mode commands set the mode of any partition other than the one being programmed, using 0xFF→2'b00, 0x70→2'b01, 0x90→2'b10, 0x98→2'b11. Read-mode commands to the programmed partition are ignored.
- R12: While idle, a read-mode command sets the mode of the named partition one cycle later, using the same code-to-mode mapping. Partition i's mode sits at bits [2i+1:2i] of `partModes`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Command byte valid this cycle |
| cmdData | input | 8 | Command byte |
| cmdPart | input | PART_W | Partition the command is addressed to |
| progStart | input | 1 | Start a program operation |
| progPart | input | PART_W | Partition to program |
| progLen | input | LEN_W | Number of checkpoints in the program |
| eraseSusp | input | 1 | Erase-suspended flag from the erase engine |
| status | output | 8 | Status byte: bit 7 ready, bit 6 erase suspended, bit 2 program suspended |
| partModes | output | 2*NPART | Read mode per partition |
| progCount | output | LEN_W | Checkpoints completed |

## Verification
Every output is registered. A command, start strobe or erase flag sampled on a rising edge shows on the outputs one cycle later. A pending suspend shows on the edge of the next checkpoint, which comes `CHK_INTERVAL` cycles after the previous one or after the start or resume. The bench drives inputs on the falling edge and steps its behavioural model on the same rising edge as the design. It compares every output on the following falling edge, so each result is checked in the cycle it is due. Directed checks taken right after a command's edge pin the single-cycle latencies. Checks taken after waiting for bit 7 pin the checkpoint-aligned ones.

// File: rtl/fscPkg.sv
package fscPkg;

  localparam logic [7:0] CMD_SUSPEND = 8'hB0;
  localparam logic [7:0] CMD_RESUME  = 8'hD0;
  localparam logic [7:0] CMD_ARRAY   = 8'hFF;
  localparam logic [7:0] CMD_STATUS  = 8'h70;
  localparam logic [7:0] CMD_IDENT   = 8'h90;
  localparam logic [7:0] CMD_QUERY   = 8'h98;

  localparam logic [1:0] MODE_ARRAY  = 2'b00;
  localparam logic [1:0] MODE_STATUS = 2'b01;
  localparam logic [1:0] MODE_IDENT  = 2'b10;
  localparam logic [1:0] MODE_QUERY  = 2'b11;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_SUSP = 2'd2
  } ctlState_t;

  typedef struct packed {
    logic       startProg;
    logic       advance;
    logic       setMode;
    logic [1:0] modeVal;
    logic       doSuspend;
    logic       doResume;
    logic       doComplete;
  } ctlStrobes_t;

  // {hit, mode}
  function automatic logic [2:0] decodeRead(input logic [7:0] code);
    case (code)
      CMD_ARRAY:  return {1'b1, MODE_ARRAY};
      CMD_STATUS: return {1'b1, MODE_STATUS};
      CMD_IDENT:  return {1'b1, MODE_IDENT};
      CMD_QUERY:  return {1'b1, MODE_QUERY};
      default:    return 3'b000;
    endcase
  endfunction

endpackage

// File: rtl/fscControl.sv
module fscControl
  import fscPkg::*;
#(
  parameter int PART_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [7:0]        cmdData,
  input  logic [PART_W-1:0] cmdPart,
  input  logic              progStart,
  input  logic [PART_W-1:0] busyPart,
  input  logic              atChk,
  input  logic              lastChk,
  output ctlStrobes_t       str
);

  ctlState_t state, stateNext;
  logic      pend, pendNext;
  logic [2:0] rdDec;
  logic      readHit, suspCmd, resCmd;

  assign rdDec   = decodeRead(cmdData);
  assign readHit = cmdValid && rdDec[2];
  assign suspCmd = cmdValid && (cmdData == CMD_SUSPEND);
  assign resCmd  = cmdValid && (cmdData == CMD_RESUME);

  always_comb begin
    str         = '0;
    str.modeVal = rdDec[1:0];
    stateNext   = state;
    case (state)
      ST_IDLE: begin
        str.setMode   = readHit;
        str.startProg = progStart;
        if (progStart) stateNext = ST_RUN;
      end
      ST_RUN: begin
        str.advance = 1'b1;
        str.setMode = readHit && (cmdPart != busyPart);
        if (atChk) begin
          if (lastChk) begin
            str.doComplete = 1'b1;
            stateNext      = ST_IDLE;
          end else if (pend) begin
            str.doSuspend = 1'b1;
            stateNext     = ST_SUSP;
          end
        end
      end
      ST_SUSP: begin
        str.setMode = readHit;
        if (resCmd) begin
          str.doResume = 1'b1;
          stateNext    = ST_RUN;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    pendNext = pend;
    if (str.doSuspend || str.doComplete) pendNext = 1'b0;
    else if (state == ST_RUN && suspCmd) pendNext = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      pend  <= 1'b0;
    end else begin
      state <= stateNext;
      pend  <= pendNext;
    end
  end

  // R4
  susp_at_chk_chk: assert property (@(posedge clk) disable iff (!rstN)
    str.doSuspend |-> atChk);

  // R7
  susp_filter_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SUSP && !(cmdValid && (rdDec[2] || cmdData == CMD_RESUME)))
      |=> (state == ST_SUSP));

  // R9
  idle_susp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !progStart && suspCmd) |=> (state == ST_IDLE && !pend));

endmodule

// File: rtl/fscDatapath.sv
module fscDatapath
  import fscPkg::*;
#(
  parameter int NPART        = 4,
  parameter int PART_W       = 2,
  parameter int LEN_W        = 8,
  parameter int CHK_INTERVAL = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobes_t        str,
  input  logic [PART_W-1:0]  cmdPart,
  input  logic [PART_W-1:0]  progPart,
  input  logic [LEN_W-1:0]   progLen,
  input  logic               eraseSusp,
  output logic [7:0]         status,
  output logic [2*NPART-1:0] partModes,
  output logic [LEN_W-1:0]   progCount,
  output logic [PART_W-1:0]  busyPart,
  output logic               atChk,
  output logic               lastChk
);

  localparam int SUB_W = (CHK_INTERVAL > 1) ? $clog2(CHK_INTERVAL) : 1;
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(CHK_INTERVAL - 1);

  logic [SUB_W-1:0] subCnt;
  logic [LEN_W-1:0] lenReg;
  logic             rdy, pSusp, eSusp;

  assign atChk   = (subCnt == SUB_LAST);
  assign lastChk = ({1'b0, progCount} + (LEN_W+1)'(1)) >= {1'b0, lenReg};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      subCnt    <= '0;
      progCount <= '0;
      lenReg    <= LEN_W'(1);
      busyPart  <= '0;
    end else if (str.startProg) begin
      subCnt    <= '0;
      progCount <= '0;
      lenReg    <= (progLen == '0) ? LEN_W'(1) : progLen;
      busyPart  <= progPart;
    end else if (str.advance) begin
      if (atChk) begin
        subCnt    <= '0;
        progCount <= progCount + LEN_W'(1);
      end else begin
        subCnt <= subCnt + SUB_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdy   <= 1'b1;
      pSusp <= 1'b0;
      eSusp <= 1'b0;
    end else begin
      eSusp <= eraseSusp;
      if (str.startProg || str.doResume) rdy <= 1'b0;
      else if (str.doSuspend || str.doComplete) rdy <= 1'b1;
      if (str.doSuspend) pSusp <= 1'b1;
      else if (str.doResume) pSusp <= 1'b0;
    end
  end

  assign status = {rdy, eSusp, 3'b000, pSusp, 2'b00};

  for (genvar i = 0; i < NPART; i++) begin : g_part
    logic [1:0] modeReg;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) modeReg <= MODE_ARRAY;
      else if (str.startProg && progPart == PART_W'(i)) modeReg <= MODE_STATUS;
      else if (str.setMode && cmdPart == PART_W'(i)) modeReg <= str.modeVal;
    end
    assign partModes[2*i+1:2*i] = modeReg;
  end

  // R4
  susp_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    pSusp |-> rdy);

  // R4
  count_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pSusp && $past(pSusp)) |-> $stable(progCount));

  // R8
  resume_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    str.doResume |=> (!rdy && !pSusp));

  // R3
  count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdy |-> (progCount < lenReg));

endmodule

// File: rtl/flashSuspendCtl.sv
module flashSuspendCtl
  import fscPkg::*;
#(
  parameter int NPART        = 4,
  parameter int LEN_W        = 8,
  parameter int CHK_INTERVAL = 4,
  localparam int PART_W      = (NPART > 1) ? $clog2(NPART) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmdValid,
  input  logic [7:0]         cmdData,
  input  logic [PART_W-1:0]  cmdPart,
  input  logic               progStart,
  input  logic [PART_W-1:0]  progPart,
  input  logic [LEN_W-1:0]   progLen,
  input  logic               eraseSusp,
  output logic [7:0]         status,
  output logic [2*NPART-1:0] partModes,
  output logic [LEN_W-1:0]   progCount
);

  ctlStrobes_t       str;
  logic [PART_W-1:0] busyPart;
  logic              atChk, lastChk;

  fscControl #(.PART_W(PART_W)) u_ctl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdData(cmdData),
    .cmdPart(cmdPart), .progStart(progStart), .busyPart(busyPart),
    .atChk(atChk), .lastChk(lastChk), .str(str)
  );

  fscDatapath #(
    .NPART(NPART), .PART_W(PART_W), .LEN_W(LEN_W), .CHK_INTERVAL(CHK_INTERVAL)
  ) u_dp (
    .clk(clk), .rstN(rstN), .str(str), .cmdPart(cmdPart),
    .progPart(progPart), .progLen(progLen), .eraseSusp(eraseSusp),
    .status(status), .partModes(partModes), .progCount(progCount),
    .busyPart(busyPart), .atChk(atChk), .lastChk(lastChk)
  );

endmodule

// File: tb/tb_flashSuspendCtl.sv
module tb_flashSuspendCtl;

  localparam int NP  = 4;
  localparam int LW  = 8;
  localparam int CHK = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cmdValid = 1'b0;
  logic [7:0]    cmdData = 8'h00;
  logic [1:0]    cmdPart = 2'd0;
  logic          progStart = 1'b0;
  logic [1:0]    progPart = 2'd0;
  logic [LW-1:0] progLen = '0;
  logic          eraseSusp = 1'b0;
  logic [7:0]    status;
  logic [2*NP-1:0] partModes;
  logic [LW-1:0] progCount;

  flashSuspendCtl #(.NPART(NP), .LEN_W(LW), .CHK_INTERVAL(CHK)) dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdData(cmdData),
    .cmdPart(cmdPart), .progStart(progStart), .progPart(progPart),
    .progLen(progLen), .eraseSusp(eraseSusp), .status(status),
    .partModes(partModes), .progCount(progCount)
  );

  always #5 clk = ~clk;

  int    errors = 0;
  int    checks = 0;
  bit    done = 0;
  string curReq = "R1";

  // behavioural reference: 0 idle, 1 running, 2 suspended
  int mState, mSub, mCount, mLen, mPart;
  bit mPend, mRdy, mSusp, mErase;
  int mModes [NP];

  function automatic int readCode(input logic [7:0] c);
    case (c)
      8'hFF: return 0;
      8'h70: return 1;
      8'h90: return 2;
      8'h98: return 3;
      default: return -1;
    endcase
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mState = 0; mSub = 0; mCount = 0; mLen = 1; mPart = 0;
      mPend = 0; mRdy = 1; mSusp = 0; mErase = 0;
      foreach (mModes[k]) mModes[k] = 0;
    end else begin
      automatic int  rc = cmdValid ? readCode(cmdData) : -1;
      automatic bit  pendOld = mPend;
      case (mState)
        0: begin
          if (rc >= 0) mModes[cmdPart] = rc;
          if (progStart) begin
            mState = 1; mSub = 0; mCount = 0;
            mLen = (progLen == 0) ? 1 : int'(progLen);
            mPart = progPart; mModes[progPart] = 1; mRdy = 0;
          end
        end
        1: begin
          if (cmdValid && cmdData == 8'hB0) mPend = 1;
          if (rc >= 0 && int'(cmdPart) != mPart) mModes[cmdPart] = rc;
          if (mSub == CHK - 1) begin
            mSub = 0; mCount++;
            if (mCount >= mLen) begin
              mState = 0; mRdy = 1; mPend = 0;
            end else if (pendOld) begin
              mState = 2; mRdy = 1; mSusp = 1; mPend = 0;
            end
          end else mSub++;
        end
        default: begin
          if (rc >= 0) mModes[cmdPart] = rc;
          if (cmdValid && cmdData == 8'hD0) begin
            mState = 1; mRdy = 0; mSusp = 0;
          end
        end
      endcase
      mErase = eraseSusp;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !done) begin
      automatic logic [7:0] expStat = {mRdy, mErase, 3'b000, mSusp, 2'b00};
      automatic logic [2*NP-1:0] expModes;
      for (int k = 0; k < NP; k++) expModes[2*k +: 2] = 2'(mModes[k]);
      chk({curReq, " model status"}, 32'(status), 32'(expStat));
      chk({curReq, " model modes"}, 32'(partModes), 32'(expModes));
      chk({curReq, " model count"}, 32'(progCount), 32'(mCount));
    end
  end

  task automatic report();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    report();
  end

  task automatic sendCmd(input logic [7:0] c, input logic [1:0] p);
    @(negedge clk);
    cmdValid = 1'b1; cmdData = c; cmdPart = p;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic startProg(input logic [1:0] p, input int len);
    @(negedge clk);
    progStart = 1'b1; progPart = p; progLen = LW'(len);
    @(negedge clk);
    progStart = 1'b0;
  endtask

  task automatic waitReady();
    for (int n = 0; n < 400; n++) begin
      if (status[7]) return;
      @(negedge clk);
    end
  endtask

  function automatic logic [1:0] modeOf(input int p);
    return partModes[2*p +: 2];
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1
    curReq = "R1";
    chk("R1 status", 32'(status), 32'h80);
    chk("R1 modes", 32'(partModes), 32'h0);
    chk("R1 count", 32'(progCount), 32'h0);

    // R12 idle read modes
    curReq = "R12";
    sendCmd(8'h90, 2'd1); chk("R12 ident", 32'(modeOf(1)), 32'h2);
    sendCmd(8'h98, 2'd2); chk("R12 query", 32'(modeOf(2)), 32'h3);
    sendCmd(8'h70, 2'd3); chk("R12 status mode", 32'(modeOf(3)), 32'h1);
    sendCmd(8'hFF, 2'd3); chk("R12 array", 32'(modeOf(3)), 32'h0);

    // R9 suspend while idle
    curReq = "R9";
    sendCmd(8'hB0, 2'd0); chk("R9 idle suspend", 32'(status), 32'h80);
    repeat (6) @(negedge clk);
    chk("R9 still ready", 32'(status), 32'h80);

    // R2, R3, R11 plain program
    curReq = "R2";
    startProg(2'd0, 3);
    chk("R2 busy", 32'(status[7]), 32'h0);
    chk("R2 status mode", 32'(modeOf(0)), 32'h1);
    curReq = "R11";
    sendCmd(8'h90, 2'd2); chk("R11 other part", 32'(modeOf(2)), 32'h2);
    sendCmd(8'hFF, 2'd0); chk("R11 busy part", 32'(modeOf(0)), 32'h1);
    curReq = "R2";
    startProg(2'd3, 7); chk("R2 start ignored", 32'(modeOf(3)), 32'h0);
    curReq = "R3";
    waitReady();
    chk("R3 done status", 32'(status), 32'h80);
    chk("R3 final count", 32'(progCount), 32'h3);

    // R4..R8 suspended program
    curReq = "R4";
    startProg(2'd1, 5);
    repeat (2) @(negedge clk);
    curReq = "R5";
    sendCmd(8'hB0, 2'd3);
    chk("R4 no immediate", 32'(status), 32'h00);
    chk("R5 target mode kept", 32'(modeOf(3)), 32'h0);
    curReq = "R4";
    waitReady();
    chk("R4 suspended", 32'(status), 32'h84);
    begin
      automatic logic [LW-1:0] held = progCount;
      chk("R4 count below len", 32'(held < 5), 32'h1);
      repeat (6) @(negedge clk);
      chk("R4 count frozen", 32'(progCount), 32'(held));
      curReq = "R6";
      chk("R6 status mode kept", 32'(modeOf(1)), 32'h1);
      curReq = "R7";
      sendCmd(8'h40, 2'd1); chk("R7 0x40", 32'(status), 32'h84);
      sendCmd(8'h20, 2'd0); chk("R7 0x20 mode", 32'(modeOf(0)), 32'h1);
      sendCmd(8'hB0, 2'd1); chk("R7 repeat suspend", 32'(status), 32'h84);
      startProg(2'd2, 2);   chk("R7 start ignored", 32'(progCount), 32'(held));
      chk("R7 start mode", 32'(modeOf(2)), 32'h2);
      sendCmd(8'h98, 2'd2); chk("R7 read accepted", 32'(modeOf(2)), 32'h3);
      curReq = "R6";
      sendCmd(8'hFF, 2'd1); chk("R6 read array", 32'(modeOf(1)), 32'h0);
      curReq = "R8";
      sendCmd(8'hD0, 2'd0);
      chk("R8 resumed", 32'(status), 32'h00);
      chk("R8 count kept", 32'(progCount), 32'(held));
      waitReady();
      chk("R8 complete", 32'(status), 32'h80);
      chk("R8 final count", 32'(progCount), 32'h5);
      sendCmd(8'hD0, 2'd0); chk("R8 stray resume", 32'(status), 32'h80);
    end

    // R10 nested under erase suspend
    curReq = "R10";
    @(negedge clk); eraseSusp = 1'b1;
    @(negedge clk);
    chk("R10 erase flag", 32'(status), 32'hC0);
    startProg(2'd2, 4);
    sendCmd(8'hB0, 2'd0);
    waitReady();
    chk("R10 nested", 32'(status), 32'hC4);
    sendCmd(8'hD0, 2'd2);
    waitReady();
    chk("R10 complete", 32'(status), 32'hC0);
    @(negedge clk); eraseSusp = 1'b0;
    @(negedge clk);
    chk("R10 flag clear", 32'(status), 32'h80);

    // R3 zero length acts as one checkpoint
    curReq = "R3";
    startProg(2'd0, 0);
    waitReady();
    chk("R3 zero length", 32'(progCount), 32'h1);

    repeat (3) @(negedge clk);
    report();
  end

endmodule